// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of a two-wire station management bus. A host issues one request at a time: a read or a write, a flag that selects the extended (Clause 45) frame set, a 5-bit PHY address, a 21-bit register address and 16-bit write data. The block derives the management clock from the system clock, shifts the frame out on the data line through an output enable for an external tri-state pad, and turns the line around to sample read data from the PHY. When the whole sequence is finished it pulses `done_o` for one cycle and presents any read data on `rdata_o`.

For a Clause 22 request, one frame is sent, and only the low five address bits are used as the register number. For a Clause 45 request, address bits 20:16 name the device and bits 15:0 the register. The block first sends an address frame that carries the 16-bit register number, and then the read or write frame. On reads the first released bit is a turnaround check. If the PHY does not pull it low, and that PHY is not listed in a 32-bit ignore mask, the block clocks the bus 32 more times with the line released to flush the PHY, and returns all ones.

The clock phase lengths are parameters counted in system clock cycles. The high phase of every bit in which the line is released is stretched to cover the PHY's output delay.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever no request is in progress, `mdc_o` is low, `mdio_oe_o` is low, `busy_o` is low and `done_o` is low.
- R2: Every frame starts with 32 driven one bits. These are followed by a 2-bit start field, 01 for Clause 22 and 00 for Clause 45, and a 2-bit opcode. The opcodes are 10 for a Clause 22 read and 01 for a Clause 22 write. For Clause 45 they are 00 for address, 01 for write and 11 for read. All fields are sent in the order written.
- R3: After the opcode, the 5-bit PHY address and a 5-bit register field follow, each most significant bit first. For Clause 22 the register field is `req_addr_i[4:0]`.
- R4: A write or address frame drives turnaround 1 then 0, then 16 data bits MSB first. It then gives exactly one clock with the line released (`mdio_oe_o` low).
- R5: A Clause 45 request sends an address frame first. That frame has register field `req_addr_i[20:16]` and data `req_addr_i[15:0]`. The block then sends a write or read frame whose register field is also `req_addr_i[20:16]`.
- R6: A read frame releases the line after the register field and samples one turnaround bit. If that bit is 0, the block samples 16 data bits MSB first and gives one more released clock, and `rdata_o` is the sampled word.
- R7: If the sampled turnaround bit is 1 and bit `req_phy_i` of `ta_ignore_i` is 0, the block gives 32 more released clocks and `rdata_o` becomes 16'hFFFF.
- R8: If bit `req_phy_i` of `ta_ignore_i` is 1, a turnaround bit of 1 is accepted and the read proceeds as in R6.
- R9: Each MDC low phase lasts HALF_CYC cycles. Each high phase lasts HALF_CYC cycles when the line is driven and RD_HIGH_CYC cycles when it is released. `mdio_o` and `mdio_oe_o` never change while MDC is high. A request with the stretched phases takes exactly the sum of these phase lengths from acceptance to `done_o`.
- R10: A request is accepted only when `busy_o` is low. `busy_o` rises on acceptance, and requests presented while busy are ignored. `done_o` is a single-cycle pulse, issued only after the last frame of the sequence, and `busy_o` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when not busy |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_c45_i | input | 1 | 1 = Clause 45 sequence |
| req_phy_i | input | 5 | PHY address |
| req_addr_i | input | 21 | Register address (device in 20:16 for Clause 45) |
| req_wdata_i | input | 16 | Write data |
| ta_ignore_i | input | 32 | Per-PHY turnaround check bypass |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| rdata_o | output | 16 | Read result |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data toward pad |
| mdio_oe_o | output | 1 | Pad output enable |
| mdio_i | input | 1 | Data from pad |

## Verification
The bench sweeps every combination of clause and direction over spread PHY, address and data values. For reads, it covers a good turnaround, a bad turnaround with the PHY masked, and a bad turnaround with every other PHY masked, which catches a mask indexed by the wrong bit. A design that skipped the flush would finish 32 released cells early. One that trusted the bad turnaround would return the PHY's word instead of all ones. One that sent a Clause 45 access without the address frame, or put the register number in the wrong field, would show a different captured cell stream. Phase lengths are timed on every cell, so a high phase that is not stretched on released bits shows up at once, as does data that moves while MDC is high. A request pulsed in the middle of a frame must leave both the stream and the idle bus afterwards unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned PHY_W    = 5;
  localparam int unsigned ADDR_W   = 21;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned FRAME_W  = 64;
  localparam int unsigned IDX_W    = 6;
  localparam int unsigned N_PHY    = 1 << PHY_W;

  // last driven cell index: full frame vs read frame (stops after register field)
  localparam logic [IDX_W-1:0] WR_LAST  = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] RD_LAST  = IDX_W'(45);
  localparam logic [IDX_W-1:0] RX_LAST  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] FLUSH_LAST = IDX_W'(31);

  localparam logic [1:0] OP22_RD = 2'b10;
  localparam logic [1:0] OP22_WR = 2'b01;
  localparam logic [1:0] OP45_AD = 2'b00;
  localparam logic [1:0] OP45_WR = 2'b01;
  localparam logic [1:0] OP45_RD = 2'b11;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TX,
    SQ_TA,
    SQ_RX,
    SQ_TAIL
  } seq_st_e;

  function automatic logic [FRAME_W-1:0] mk_frame(
    input logic              ext,
    input logic [1:0]        op,
    input logic [PHY_W-1:0]  phy,
    input logic [4:0]        regf,
    input logic [DATA_W-1:0] data
  );
    return {32'hFFFF_FFFF, 1'b0, ~ext, op, phy, regf, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], d_i};
  end

  assign q_o = sync_q[1];
endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF_CYC    = 63,
  parameter int unsigned RD_HIGH_CYC = 88
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic long_hi_i,
  output logic mdc_o,
  output logic cell_end_o
);
  localparam int unsigned MAX_CYC = (RD_HIGH_CYC > HALF_CYC) ? RD_HIGH_CYC : HALF_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC) + 1;
  localparam logic [CW-1:0] LO_LAST  = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] HI_LAST  = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] HIR_LAST = CW'(RD_HIGH_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic [CW-1:0] hi_last;

  assign hi_last    = long_hi_i ? HIR_LAST : HI_LAST;
  assign cell_end_o = run_i && mdc_q && (cnt_q == hi_last);
  assign mdc_o      = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!mdc_q) begin
      if (cnt_q == LO_LAST) begin
        cnt_q <= '0;
        mdc_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (cell_end_o) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_c45_i,
  input  logic [PHY_W-1:0]  req_phy_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [N_PHY-1:0]  ta_ignore_i,
  input  logic              cell_end_i,
  input  logic              mdio_in_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdio_o,
  output logic              oe_o
);
  seq_st_e             st_q;
  logic [FRAME_W-1:0]  sh_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W-1:0]    tail_last_q;
  logic                rd_frame_q;
  logic                pend_q;
  logic                wr_q;
  logic [PHY_W-1:0]    phy_q;
  logic [4:0]          dev_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rx_q;
  logic                ta_fail_q;
  logic                ta_ok;

  assign ta_ok  = !mdio_in_i || ta_ignore_i[phy_q];
  assign mdio_o = sh_q[FRAME_W-1];
  assign busy_o = (st_q != SQ_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SQ_IDLE;
      sh_q        <= '0;
      idx_q       <= '0;
      tail_last_q <= '0;
      rd_frame_q  <= 1'b0;
      pend_q      <= 1'b0;
      wr_q        <= 1'b0;
      phy_q       <= '0;
      dev_q       <= '0;
      wdata_q     <= '0;
      rx_q        <= '0;
      ta_fail_q   <= 1'b0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
      oe_o        <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (req_valid_i) begin
          wr_q      <= req_write_i;
          phy_q     <= req_phy_i;
          dev_q     <= req_addr_i[20:16];
          wdata_q   <= req_wdata_i;
          ta_fail_q <= 1'b0;
          idx_q     <= '0;
          oe_o      <= 1'b1;
          st_q      <= SQ_TX;
          if (req_c45_i) begin
            sh_q       <= mk_frame(1'b1, OP45_AD, req_phy_i, req_addr_i[20:16], req_addr_i[15:0]);
            rd_frame_q <= 1'b0;
            pend_q     <= 1'b1;
          end else begin
            sh_q       <= mk_frame(1'b0, req_write_i ? OP22_WR : OP22_RD, req_phy_i,
                                   req_addr_i[4:0], req_wdata_i);
            rd_frame_q <= !req_write_i;
            pend_q     <= 1'b0;
          end
        end
        SQ_TX: if (cell_end_i) begin
          sh_q <= sh_q << 1;
          if (idx_q == (rd_frame_q ? RD_LAST : WR_LAST)) begin
            oe_o        <= 1'b0;
            idx_q       <= '0;
            tail_last_q <= '0;
            st_q        <= rd_frame_q ? SQ_TA : SQ_TAIL;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        SQ_TA: if (cell_end_i) begin
          idx_q <= '0;
          if (ta_ok) begin
            st_q <= SQ_RX;
          end else begin
            ta_fail_q   <= 1'b1;
            tail_last_q <= FLUSH_LAST;
            st_q        <= SQ_TAIL;
          end
        end
        SQ_RX: if (cell_end_i) begin
          rx_q <= {rx_q[DATA_W-2:0], mdio_in_i};
          if (idx_q == RX_LAST) begin
            idx_q       <= '0;
            tail_last_q <= '0;
            st_q        <= SQ_TAIL;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        SQ_TAIL: if (cell_end_i) begin
          if (idx_q == tail_last_q) begin
            idx_q <= '0;
            if (pend_q) begin
              pend_q     <= 1'b0;
              sh_q       <= mk_frame(1'b1, wr_q ? OP45_WR : OP45_RD, phy_q, dev_q, wdata_q);
              rd_frame_q <= !wr_q;
              oe_o       <= 1'b1;
              st_q       <= SQ_TX;
            end else begin
              st_q   <= SQ_IDLE;
              done_o <= 1'b1;
              if (rd_frame_q) rdata_o <= ta_fail_q ? {DATA_W{1'b1}} : rx_q;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 63,
  parameter int unsigned RD_HIGH_CYC = 88
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic        req_c45_i,
  input  logic [4:0]  req_phy_i,
  input  logic [20:0] req_addr_i,
  input  logic [15:0] req_wdata_i,
  input  logic [31:0] ta_ignore_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic mdio_s;
  logic cell_end;

  mdio_in_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mdio_i),
    .q_o    (mdio_s)
  );

  // released cells get the stretched high phase for PHY output delay
  mdio_mdc_gen #(
    .HALF_CYC    (HALF_CYC),
    .RD_HIGH_CYC (RD_HIGH_CYC)
  ) u_mdc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (busy_o),
    .long_hi_i  (!mdio_oe_o),
    .mdc_o      (mdc_o),
    .cell_end_o (cell_end)
  );

  mdio_frame_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_c45_i   (req_c45_i),
    .req_phy_i   (req_phy_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .ta_ignore_i (ta_ignore_i),
    .cell_end_i  (cell_end),
    .mdio_in_i   (mdio_s),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .mdio_o      (mdio_o),
    .oe_o        (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned HALF_CYC    = 63,
  parameter int unsigned RD_HIGH_CYC = 88
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o
);
  localparam int unsigned MAX_CYC = (RD_HIGH_CYC > HALF_CYC) ? RD_HIGH_CYC : HALF_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC) + 2;

  logic [CW-1:0] hi_cnt;
  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= mdc_o ? hi_cnt + 1'b1 : '0;
      lo_cnt <= (!mdc_o && busy_o) ? lo_cnt + 1'b1 : '0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  p_preamble_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (mdio_oe_o && mdio_o));

  p_hold_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  p_oe_on_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$stable(mdio_oe_o)) |-> $fell(mdc_o));

  p_high_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_o) |-> (hi_cnt == CW'($past(mdio_oe_o) ? HALF_CYC : RD_HIGH_CYC)));

  p_low_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> (lo_cnt == CW'(HALF_CYC)));

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_with_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind mdio_master mdio_master_chk #(
  .HALF_CYC    (HALF_CYC),
  .RD_HIGH_CYC (RD_HIGH_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int H = 2;
  localparam int R = 3;
  localparam int MAXC = 200;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic        req_c45_i = 1'b0;
  logic [4:0]  req_phy_i = '0;
  logic [20:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [31:0] ta_ignore_i = '0;
  logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
  logic [15:0] rdata_o;
  logic        mdio_i = 1'b1;

  mdio_master #(.HALF_CYC(H), .RD_HIGH_CYC(R)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_c45_i(req_c45_i), .req_phy_i(req_phy_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .ta_ignore_i(ta_ignore_i), .busy_o(busy_o), .done_o(done_o),
    .rdata_o(rdata_o), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // cell capture and PHY responder
  logic exp_oe [MAXC];
  logic exp_bit [MAXC];
  logic got_oe [MAXC];
  logic got_bit [MAXC];
  logic resp [MAXC];
  int n_exp, n_got, n_resp, r_idx, exp_time;

  always @(posedge mdc_o) begin
    if (n_got < MAXC) begin
      got_oe[n_got]  = mdio_oe_o;
      got_bit[n_got] = mdio_o;
    end
    n_got = n_got + 1;
    if (!mdio_oe_o) begin
      mdio_i <= (r_idx < n_resp) ? resp[r_idx] : 1'b1;
      r_idx = r_idx + 1;
    end else begin
      mdio_i <= 1'b1;
    end
  end

  // phase timing monitor (R9)
  int tim_err = 0;
  int hi_run = 0;
  int lo_run = 0;
  logic prev_mdc = 1'b0, prev_mdio = 1'b0, prev_oe = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mdc_o) hi_run++;
      if (!mdc_o && busy_o) lo_run++;
      if (prev_mdc && mdc_o && (mdio_o !== prev_mdio || mdio_oe_o !== prev_oe)) tim_err++;
      if (prev_mdc && !mdc_o) begin
        if (hi_run != (prev_oe ? H : R)) tim_err++;
        hi_run = 0;
      end
      if (!prev_mdc && mdc_o) begin
        if (lo_run != H) tim_err++;
        lo_run = 0;
      end
      if (!busy_o) lo_run = 0;
      prev_mdc = mdc_o; prev_mdio = mdio_o; prev_oe = mdio_oe_o;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add_cell(input logic oe, input logic b);
    exp_oe[n_exp] = oe;
    exp_bit[n_exp] = b;
    n_exp++;
    exp_time += oe ? 2*H : H + R;
  endtask

  task automatic add_frame(input logic st1, input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] regf, input logic [15:0] data,
                           input bit is_rd, input bit ok);
    for (int i = 0; i < 32; i++) add_cell(1'b1, 1'b1);
    add_cell(1'b1, 1'b0);
    add_cell(1'b1, st1);
    add_cell(1'b1, op[1]);
    add_cell(1'b1, op[0]);
    for (int i = 4; i >= 0; i--) add_cell(1'b1, phy[i]);
    for (int i = 4; i >= 0; i--) add_cell(1'b1, regf[i]);
    if (!is_rd) begin
      add_cell(1'b1, 1'b1);
      add_cell(1'b1, 1'b0);
      for (int i = 15; i >= 0; i--) add_cell(1'b1, data[i]);
      add_cell(1'b0, 1'b0);
    end else begin
      add_cell(1'b0, 1'b0);
      for (int i = 0; i < (ok ? 17 : 32); i++) add_cell(1'b0, 1'b0);
    end
  endtask

  task automatic run_txn(input bit wr, input bit c45, input logic [4:0] phy,
                         input logic [20:0] addr, input logic [15:0] wdata,
                         input logic [31:0] mask, input logic ta_val,
                         input logic [15:0] rd_pat, input bit inject);
    bit ok;
    int t0, wait_n, bad, n_after;
    ok = (ta_val == 1'b0) || mask[phy];
    n_exp = 0; exp_time = 0; n_resp = 0;
    if (c45) begin
      add_frame(1'b0, 2'b00, phy, addr[20:16], addr[15:0], 0, 1);
      add_frame(1'b0, wr ? 2'b01 : 2'b11, phy, addr[20:16], wdata, !wr, ok);
      resp[n_resp++] = 1'b1;
    end else begin
      add_frame(1'b1, wr ? 2'b01 : 2'b10, phy, addr[4:0], wdata, !wr, ok);
    end
    if (!wr) begin
      resp[n_resp++] = ta_val;
      for (int i = 15; i >= 0; i--) resp[n_resp++] = rd_pat[i];
    end
    n_got = 0; r_idx = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_c45_i = c45; req_phy_i = phy;
    req_addr_i = addr; req_wdata_i = wdata; ta_ignore_i = mask;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    t0 = cyc;
    check(busy_o === 1'b1, "R10 busy after accept", {31'd0, busy_o}, 32'd1);
    if (inject) begin
      repeat (40) @(negedge clk_i);
      req_valid_i = 1'b1; req_write_i = ~wr; req_c45_i = ~c45; req_phy_i = ~phy;
      req_addr_i = ~addr; req_wdata_i = ~wdata;
      @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    wait_n = 0;
    while (!done_o && wait_n < 5000) begin
      @(negedge clk_i);
      wait_n++;
    end
    check(cyc - t0 == exp_time, "R9 sequence duration", cyc - t0, exp_time);
    bad = (n_got != n_exp) ? 1 : 0;
    for (int i = 0; i < n_exp && i < n_got && i < MAXC; i++) begin
      if (got_oe[i] !== exp_oe[i]) bad++;
      else if (exp_oe[i] && got_bit[i] !== exp_bit[i]) bad++;
    end
    if (c45) check(bad == 0, "R5 address frame then access frame", n_got, n_exp);
    else if (wr) check(bad == 0, "R2 R3 R4 write frame cells", n_got, n_exp);
    else check(bad == 0, "R2 R3 read frame cells", n_got, n_exp);
    if (!wr) begin
      if (ta_val == 1'b0)
        check(rdata_o === rd_pat, "R6 read data", rdata_o, rd_pat);
      else if (ok)
        check(rdata_o === rd_pat, "R8 masked turnaround", rdata_o, rd_pat);
      else
        check(rdata_o === 16'hFFFF, "R7 flush returns ones", rdata_o, 16'hFFFF);
    end
    @(negedge clk_i);
    check(done_o === 1'b0 && busy_o === 1'b0, "R10 done single pulse",
          {30'd0, done_o, busy_o}, 32'd0);
    if (inject) begin
      n_after = n_got;
      repeat (30) @(negedge clk_i);
      check(busy_o === 1'b0 && mdc_o === 1'b0 && n_got == n_after,
            "R10 request while busy ignored", n_got, n_after);
    end
  endtask

  bit wd_fired = 0;
  initial begin
    repeat (190000) @(posedge clk_i);
    wd_fired = 1;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    n_got = 0; r_idx = 0; n_resp = 0;
    repeat (3) @(negedge clk_i);
    check(mdc_o === 1'b0 && mdio_oe_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
          "R1 reset state", {28'd0, mdc_o, mdio_oe_o, busy_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(mdc_o === 1'b0 && mdio_oe_o === 1'b0 && busy_o === 1'b0,
          "R1 idle after reset", {29'd0, mdc_o, mdio_oe_o, busy_o}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      for (int op = 0; op < 4; op++) begin
        logic [4:0]  phy;
        logic [20:0] addr;
        logic [15:0] wd, rp;
        phy  = 5'((k * 7 + 3 + op) % 32);
        addr = 21'((k * 32'h2A5B3 + op * 32'h1_1111) & 32'h1F_FFFF);
        wd   = 16'((k * 16'h3C5A) ^ 16'hA5A5 ^ (op << 4));
        rp   = 16'((k * 16'h1357) ^ 16'h5A3C);
        if (op[0]) begin
          run_txn(1'b1, op[1], phy, addr, wd, 32'h0, 1'b0, rp, k == 3);
        end else begin
          run_txn(1'b0, op[1], phy, addr, wd, 32'h0, 1'b0, rp, k == 3);
          run_txn(1'b0, op[1], phy, addr, wd, 32'h1 << phy, 1'b1, rp, 0);
          run_txn(1'b0, op[1], phy, addr, wd, ~(32'h1 << phy), 1'b1, rp, 0);
        end
      end
    end
    check(mdc_o === 1'b0 && mdio_oe_o === 1'b0, "R1 idle at end", {30'd0, mdc_o, mdio_oe_o}, 32'd0);
    check(tim_err == 0, "R9 phase lengths and hold", tim_err, 0);
    if (!wd_fired) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule